// File: doc/BRIEF.md
# Multi-Level Prioritized Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines into a pending register, gates them with a software-written enable register, and sorts them into up to six priority levels through a per-level line mask fixed at build time. On every cycle it reports the highest level that has an enabled, pending line and that lies strictly above the processor's current effective interrupt level.

When the core accepts the request, the block does three things. It stores the interrupted PC and the pre-entry status word in per-level save registers. It raises the status interrupt level to the taken level and sets the exception-mode bit. It then issues a one-cycle redirect to the entry address for that level. Level 1 follows its own entry path. It records a cause code and picks one of three entry addresses (kernel, user or double exception) from the status bits. When the exception-mode bit is already set, it keeps the PC in a separate double-exception save register.

A return operation restores the status word and PC for a chosen level. A wait operation only rewrites the interrupt-level field. Each status change leads to fresh arbitration on the next cycle.

Top module: `irq_level_ctrl`

## Requirements
- R1: `pending` copies each request line below `NUM_LINES` (default 12) on every clock edge, so a line that drops clears its pending bit. Lines at index `NUM_LINES` or above never raise a request, even when a level mask names them.
- R2: A line is a candidate for level L only when its bit is set in mask L, in pending and in enable. `irq_lvl` is the highest such level (1..`NUM_LEVELS`) and `irq_req` is high exactly when one exists. In the default build, level L owns lines 2L-2 and 2L-1.
- R3: Only levels strictly above the effective level qualify. The effective level is `status[3:0]`; while `status[4]` (exception mode) is set it is raised to at least `EXCM_LEVEL` (default 0).
- R4: Accepting a request (`irq_req` and `take_ack` high at a clock edge) at level L of 2 or more does three things: it stores `cur_pc` as the saved PC of level L, stores the old status as the saved status of level L, and pulses `redirect_vld` one cycle later with `redirect_pc` = `VEC_BASE + L*VEC_STEP` (0x400 + L*0x20).
- R5: Accepting level 1 with `status[4]` clear sets `exc_cause` to 4 and stores `cur_pc` as saved PC 1. It redirects to `KERN_VEC` (0x300), or to `USER_VEC` (0x340) when `status[5]` (user mode) is set.
- R6: Accepting level 1 with `status[4]` set redirects to `DBL_VEC` (0x3C0). It stores `cur_pc` in the double-exception save register, or in saved PC 1 when `HAS_DEPC` = 0, and leaves saved PC 1 untouched otherwise.
- R7: On any acceptance, `status[3:0]` becomes L, `status[4]` becomes 1 and `status[7:5]` keep their values.
- R8: A return (`rfi_go`) for level N with 2 <= N <= `NUM_LEVELS` loads the status from saved status N and redirects one cycle later to saved PC N. It is ignored (no redirect, status unchanged) in user mode or for any other N.
- R9: A wait (`wait_go`) writes `wait_lvl` into `status[3:0]`, leaves the other status bits unchanged, issues no redirect, and the new level governs arbitration from the next cycle.
- R10: A status write (`st_we`) appears on `status` after the edge, and arbitration follows the new value in that same cycle.
- R11: After reset, `status` is 0x1F, and `irq_req`, `redirect_vld` and `exc_cause` are 0.
- R12: `epc_rd` shows the double-exception save register for `rd_sel` = 0, saved PC N for `rd_sel` = N, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lines | input | 32 | Level-sensitive interrupt request lines |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 32 | Enable register write data |
| st_we | input | 1 | Status word write strobe |
| st_wdata | input | 8 | Status word write data |
| cur_pc | input | 32 | PC of the instruction about to be interrupted |
| take_ack | input | 1 | Core accepts the current request |
| rfi_go | input | 1 | Return-from-interrupt strobe |
| rfi_lvl | input | 4 | Level the return applies to |
| wait_go | input | 1 | Wait-for-interrupt strobe |
| wait_lvl | input | 4 | Level written by the wait |
| rd_sel | input | 4 | Saved-PC read select |
| irq_req | output | 1 | A qualifying level is pending |
| irq_lvl | output | 4 | Highest qualifying level, 0 if none |
| status | output | 8 | Status word: [3:0] level, [4] exception mode, [5] user mode, [7:6] spare |
| exc_cause | output | 6 | Cause code, 4 after a level-1 entry |
| epc_rd | output | 32 | Selected saved PC |
| redirect_vld | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Redirect target |

## Verification
A request line, enable write or status write is registered at one edge, and `irq_req`/`irq_lvl` follow from those registers in the same cycle. So every arbitration check drives its stimulus before an edge and samples in the low phase right after that edge. Acceptance and return are also registered once. Their `redirect_vld`, `redirect_pc`, `status` and `exc_cause` are therefore sampled in the low phase after the accepting edge, and `redirect_vld` is checked to be low again one cycle later. Saved PCs are read combinationally through `rd_sel` one cycle after the entry that wrote them. All 4096 patterns of the twelve lines are swept against four status words, with the expected level computed from the line-pair ownership rule.

// File: rtl/irq_pkg.sv
// Package: shared widths, status layout and reset value for the interrupt controller.
package irq_pkg;
    localparam int MAX_LINES  = 32;
    localparam int MAX_LEVELS = 6;
    localparam int PC_W       = 32;
    localparam int CAUSE_W    = 6;
    localparam int LVL_W      = 4;

    // Status word layout: spare bits, user mode, exception mode, level field.
    typedef struct packed {
        logic [1:0]       spare;
        logic             um;
        logic             excm;
        logic [LVL_W-1:0] ilvl;
    } stat_t;

    localparam logic [7:0] STAT_RESET = 8'h1F;
endpackage

// File: rtl/irq_pend_mask.sv
// Pending and enable registers.
// Assumes request lines are already synchronous to clk; lines at index
// NUM_LINES and above are tied off and never reach the arbiter.
module irq_pend_mask #(
    parameter int NUM_LINES = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [irq_pkg::MAX_LINES-1:0]  req_lines,
    input  logic                           en_we,
    input  logic [irq_pkg::MAX_LINES-1:0]  en_wdata,
    output logic [irq_pkg::MAX_LINES-1:0]  pend_q,
    output logic [irq_pkg::MAX_LINES-1:0]  en_q
);
    for (genvar i = 0; i < irq_pkg::MAX_LINES; i++) begin : g_line
        if (i < NUM_LINES) begin : g_live
            // Track the request level and the enable bit of one line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[i] <= 1'b0;
                    en_q[i]   <= 1'b0;
                end else begin
                    pend_q[i] <= req_lines[i];
                    if (en_we) en_q[i] <= en_wdata[i];
                end
            end
        end else begin : g_tied
            logic unused_bit;
            assign unused_bit = req_lines[i] ^ en_wdata[i];
            assign pend_q[i]  = 1'b0;
            assign en_q[i]    = 1'b0;
        end
    end
endmodule

// File: rtl/irq_level_arb.sv
// Level arbiter: finds the highest level with a pending, enabled line in its
// mask that lies above the effective level. Purely combinational.
// Assumes LVL_MASKS holds one 32-bit mask per level, level 1 in the low slice.
module irq_level_arb #(
    parameter int                                   NUM_LEVELS = 6,
    parameter int                                   EXCM_LEVEL = 0,
    parameter logic [irq_pkg::MAX_LEVELS*32-1:0]    LVL_MASKS  = '0
) (
    input  logic [irq_pkg::MAX_LINES-1:0]  pend,
    input  logic [irq_pkg::MAX_LINES-1:0]  en,
    input  irq_pkg::stat_t                 stat,
    output logic                           req,
    output logic [irq_pkg::LVL_W-1:0]      lvl
);
    logic [NUM_LEVELS:1]          hit;
    logic [irq_pkg::LVL_W-1:0]    eff;

    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
        assign hit[l] = |(LVL_MASKS[(l-1)*32 +: 32] & pend & en);
    end

    // Effective level: level field, raised to EXCM_LEVEL in exception mode.
    always_comb begin
        eff = stat.ilvl;
        if (stat.excm && (4'(EXCM_LEVEL) > eff)) eff = 4'(EXCM_LEVEL);
    end

    // Scan upward so the highest qualifying level wins.
    always_comb begin
        lvl = '0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (hit[l] && (4'(l) > eff)) lvl = 4'(l);
        end
        req = (lvl != '0);
    end
endmodule

// File: rtl/irq_save_bank.sv
// Save registers: one PC per level, one status per level from 2 up, and an
// optional double-exception PC in slot 0. Written on acceptance only.
// Assumes take_lvl is in 1..NUM_LEVELS whenever take is high.
module irq_save_bank #(
    parameter int NUM_LEVELS = 6,
    parameter bit HAS_DEPC   = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           take,
    input  logic [irq_pkg::LVL_W-1:0]      take_lvl,
    input  logic [irq_pkg::PC_W-1:0]       cur_pc,
    input  irq_pkg::stat_t                 stat,
    input  logic [irq_pkg::LVL_W-1:0]      rd_sel,
    input  logic [irq_pkg::LVL_W-1:0]      rfi_lvl,
    output logic [irq_pkg::PC_W-1:0]       epc_rd,
    output logic [irq_pkg::PC_W-1:0]       rfi_pc,
    output irq_pkg::stat_t                 rfi_stat
);
    logic [irq_pkg::PC_W-1:0] epc_q [0:NUM_LEVELS];
    irq_pkg::stat_t           eps_q [2:NUM_LEVELS];

    logic l1_take, l1_dbl;
    assign l1_take = take && (take_lvl == 4'd1);
    assign l1_dbl  = l1_take && stat.excm && HAS_DEPC;

    if (HAS_DEPC) begin : g_depc
        // Double-exception PC, written by a level-1 entry in exception mode.
        always_ff @(posedge clk) begin
            if (!rst_n)      epc_q[0] <= '0;
            else if (l1_dbl) epc_q[0] <= cur_pc;
        end
    end else begin : g_no_depc
        assign epc_q[0] = '0;
    end

    // Level-1 PC, written unless the double-exception register takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  epc_q[1] <= '0;
        else if (l1_take && !l1_dbl) epc_q[1] <= cur_pc;
    end

    for (genvar l = 2; l <= NUM_LEVELS; l++) begin : g_lvl
        // PC and status for level l, captured on entry at that level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                epc_q[l] <= '0;
                eps_q[l] <= '0;
            end else if (take && (take_lvl == 4'(l))) begin
                epc_q[l] <= cur_pc;
                eps_q[l] <= stat;
            end
        end
    end

    // Read muxes for the saved-PC port and the return path.
    always_comb begin
        epc_rd   = '0;
        rfi_pc   = '0;
        rfi_stat = '0;
        for (int l = 0; l <= NUM_LEVELS; l++) begin
            if (rd_sel == 4'(l)) epc_rd = epc_q[l];
        end
        for (int l = 2; l <= NUM_LEVELS; l++) begin
            if (rfi_lvl == 4'(l)) begin
                rfi_pc   = epc_q[l];
                rfi_stat = eps_q[l];
            end
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
// Multi-level interrupt controller top: owns the status word, the cause
// register and the redirect output; arbitration and save storage live in
// submodules. Assumes at most one of take/return/wait/status-write matters
// per cycle; when several coincide, acceptance wins, then return, wait, write.
module irq_level_ctrl #(
    parameter int                                NUM_LINES  = 12,
    parameter int                                NUM_LEVELS = 6,
    parameter int                                EXCM_LEVEL = 0,
    parameter bit                                HAS_DEPC   = 1'b1,
    parameter logic [irq_pkg::MAX_LEVELS*32-1:0] LVL_MASKS  = {
        32'h0000_4C00, 32'h0000_0300, 32'h0000_00C0,
        32'h0000_0030, 32'h0000_000C, 32'h0000_0003},
    parameter logic [31:0]                       VEC_BASE   = 32'h0000_0400,
    parameter logic [31:0]                       VEC_STEP   = 32'h0000_0020,
    parameter logic [31:0]                       KERN_VEC   = 32'h0000_0300,
    parameter logic [31:0]                       USER_VEC   = 32'h0000_0340,
    parameter logic [31:0]                       DBL_VEC    = 32'h0000_03C0,
    parameter logic [5:0]                        LVL1_CAUSE = 6'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] req_lines,
    input  logic        en_we,
    input  logic [31:0] en_wdata,
    input  logic        st_we,
    input  logic [7:0]  st_wdata,
    input  logic [31:0] cur_pc,
    input  logic        take_ack,
    input  logic        rfi_go,
    input  logic [3:0]  rfi_lvl,
    input  logic        wait_go,
    input  logic [3:0]  wait_lvl,
    input  logic [3:0]  rd_sel,
    output logic        irq_req,
    output logic [3:0]  irq_lvl,
    output logic [7:0]  status,
    output logic [5:0]  exc_cause,
    output logic [31:0] epc_rd,
    output logic        redirect_vld,
    output logic [31:0] redirect_pc
);
    import irq_pkg::*;

    logic [MAX_LINES-1:0] pend_q, en_q;
    stat_t                stat_q, rfi_stat;
    logic [PC_W-1:0]      rfi_pc, entry_pc;
    logic                 take, rfi_ok;

    irq_pend_mask #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines),
        .en_we(en_we), .en_wdata(en_wdata), .pend_q(pend_q), .en_q(en_q)
    );

    irq_level_arb #(
        .NUM_LEVELS(NUM_LEVELS), .EXCM_LEVEL(EXCM_LEVEL), .LVL_MASKS(LVL_MASKS)
    ) u_arb (
        .pend(pend_q), .en(en_q), .stat(stat_q), .req(irq_req), .lvl(irq_lvl)
    );

    irq_save_bank #(.NUM_LEVELS(NUM_LEVELS), .HAS_DEPC(HAS_DEPC)) u_save (
        .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(irq_lvl),
        .cur_pc(cur_pc), .stat(stat_q), .rd_sel(rd_sel), .rfi_lvl(rfi_lvl),
        .epc_rd(epc_rd), .rfi_pc(rfi_pc), .rfi_stat(rfi_stat)
    );

    assign take   = irq_req && take_ack;
    assign rfi_ok = rfi_go && !stat_q.um && (rfi_lvl >= 4'd2)
                    && (rfi_lvl <= 4'(NUM_LEVELS));
    assign status = stat_q;

    // Entry address: per-level vector, or the level-1 three-way choice.
    always_comb begin
        if (irq_lvl >= 4'd2)  entry_pc = VEC_BASE + 32'(irq_lvl) * VEC_STEP;
        else if (stat_q.excm) entry_pc = DBL_VEC;
        else if (stat_q.um)   entry_pc = USER_VEC;
        else                  entry_pc = KERN_VEC;
    end

    // Status word update by priority: entry, return, wait, plain write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= stat_t'(STAT_RESET);
        end else if (take) begin
            stat_q.excm <= 1'b1;
            stat_q.ilvl <= irq_lvl;
        end else if (rfi_ok) begin
            stat_q <= rfi_stat;
        end else if (wait_go) begin
            stat_q.ilvl <= wait_lvl;
        end else if (st_we) begin
            stat_q <= stat_t'(st_wdata);
        end
    end

    // Cause register, loaded by level-1 entries.
    always_ff @(posedge clk) begin
        if (!rst_n)                           exc_cause <= '0;
        else if (take && (irq_lvl == 4'd1))   exc_cause <= LVL1_CAUSE;
    end

    // One-cycle redirect pulse with its target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld <= 1'b0;
            redirect_pc  <= '0;
        end else begin
            redirect_vld <= take || rfi_ok;
            if (take)        redirect_pc <= entry_pc;
            else if (rfi_ok) redirect_pc <= rfi_pc;
        end
    end
endmodule

// Checker: temporal properties of the controller's ports.
module irq_level_ctrl_chk #(
    parameter int NUM_LEVELS = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       take_ack,
    input logic       rfi_go,
    input logic       wait_go,
    input logic [3:0] wait_lvl,
    input logic       irq_req,
    input logic [3:0] irq_lvl,
    input logic [7:0] status
    ,input logic      redirect_vld
);
    // R3
    above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > status[3:0]));

    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl >= 4'd1 && irq_lvl <= 4'(NUM_LEVELS)));

    // R7
    entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && take_ack) |=> (redirect_vld && status[4]
            && status[3:0] == $past(irq_lvl) && status[7:5] == $past(status[7:5])));

    // R9
    wait_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_go && !rfi_go && !(irq_req && take_ack)) |=>
            (status[3:0] == $past(wait_lvl) && !redirect_vld));

    // R8
    user_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_go && status[5] && !(irq_req && take_ack)) |=> !redirect_vld);

    // R4
    idle_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfi_go && !(irq_req && take_ack)) |=> !redirect_vld);
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
    .clk(clk), .rst_n(rst_n), .take_ack(take_ack), .rfi_go(rfi_go),
    .wait_go(wait_go), .wait_lvl(wait_lvl), .irq_req(irq_req),
    .irq_lvl(irq_lvl), .status(status), .redirect_vld(redirect_vld)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_lines = '0;
    logic        en_we = 1'b0;
    logic [31:0] en_wdata = '0;
    logic        st_we = 1'b0;
    logic [7:0]  st_wdata = '0;
    logic [31:0] cur_pc = '0;
    logic        take_ack = 1'b0;
    logic        rfi_go = 1'b0;
    logic [3:0]  rfi_lvl = '0;
    logic        wait_go = 1'b0;
    logic [3:0]  wait_lvl = '0;
    logic [3:0]  rd_sel = '0;
    logic        irq_req;
    logic [3:0]  irq_lvl;
    logic [7:0]  status;
    logic [5:0]  exc_cause;
    logic [31:0] epc_rd;
    logic        redirect_vld;
    logic [31:0] redirect_pc;

    int vectors = 0;
    int misses  = 0;

    irq_level_ctrl u0 (.*);

    always #2 clk = ~clk;

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model: level L owns lines 2L-2 and 2L-1; highest above ilvl wins.
    function automatic int exp_level(input logic [11:0] pat, input logic [11:0] en,
                                     input int ilvl);
        int r = 0;
        for (int l = 1; l <= 6; l++)
            if ((((pat & en) >> (2*l-2)) & 12'h3) != 0 && l > ilvl) r = l;
        return r;
    endfunction

    task automatic set_status(input logic [7:0] v);
        st_we = 1'b1; st_wdata = v;
        tick;
        st_we = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        misses++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [7:0] svals [4];
        svals = '{8'h00, 8'h03, 8'h05, 8'h26};
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // R11 reset state
        chk("R11 status", status, 32'h1F);
        chk("R11 irq_req", irq_req, 0);
        chk("R11 redirect", redirect_vld, 0);
        chk("R11 cause", exc_cause, 0);

        en_we = 1'b1; en_wdata = 32'hFFFF_FFFF; tick; en_we = 1'b0;
        // R10 status write visible next cycle
        set_status(8'h00);
        chk("R10 status", status, 32'h00);

        // R1/R2 single lines, including ignored lines 12..15
        for (int i = 0; i < 16; i++) begin
            req_lines = 32'(1) << i;
            tick;
            chk("R1 single line lvl", irq_lvl, (i < 12) ? i/2 + 1 : 0);
            chk("R1 single line req", irq_req, (i < 12) ? 1 : 0);
        end

        // R2/R3 full sweep of line patterns against several status words
        for (int p = 0; p < 4096; p++) begin
            for (int s = 0; s < 4; s++) begin
                req_lines = 32'(p);
                st_we = 1'b1; st_wdata = svals[s];
                tick;
                st_we = 1'b0;
                chk("R3 sweep lvl", irq_lvl,
                    exp_level(12'(p), 12'hFFF, int'(svals[s][3:0])));
            end
        end

        // R2 partial enable
        req_lines = 32'hFFF; en_we = 1'b1; en_wdata = 32'h3FF; st_we = 1'b1; st_wdata = 8'h00;
        tick; en_we = 1'b0; st_we = 1'b0;
        chk("R2 partial enable", irq_lvl, 5);
        en_we = 1'b1; en_wdata = 32'h0; tick;
        chk("R2 none enabled", irq_req, 0);
        en_wdata = 32'hFFFF_FFFF; tick; en_we = 1'b0;

        // R10 re-evaluation after a status write
        req_lines = 32'h400; set_status(8'h06);
        chk("R10 blocked", irq_req, 0);
        set_status(8'h05);
        chk("R10 unblocked", irq_lvl, 6);

        // R4/R7/R8/R12 entry and return for levels 2..6
        for (int l = 2; l <= 6; l++) begin
            req_lines = '0; set_status(8'hC0);
            req_lines = 32'(1) << (2*l-2); cur_pc = 32'h1000 + 32'(l*16);
            tick;
            chk("R2 level before take", irq_lvl, l);
            take_ack = 1'b1; tick; take_ack = 1'b0;
            chk("R4 redirect vld", redirect_vld, 1);
            chk("R4 vector", redirect_pc, 32'h400 + 32'(l) * 32'h20);
            chk("R7 status", status, 32'hD0 | l);
            req_lines = '0; rd_sel = 4'(l); tick;
            chk("R4 pulse ends", redirect_vld, 0);
            chk("R12 saved pc", epc_rd, 32'h1000 + 32'(l*16));
            rfi_go = 1'b1; rfi_lvl = 4'(l); tick; rfi_go = 1'b0;
            chk("R8 return vld", redirect_vld, 1);
            chk("R8 return pc", redirect_pc, 32'h1000 + 32'(l*16));
            chk("R8 status restore", status, 32'hC0);
        end

        // R5 level 1 kernel and user paths
        req_lines = '0; set_status(8'h00);
        req_lines = 32'h1; cur_pc = 32'h2000; tick;
        take_ack = 1'b1; tick; take_ack = 1'b0;
        chk("R5 kernel vector", redirect_pc, 32'h300);
        chk("R5 cause", exc_cause, 4);
        chk("R7 level1 status", status, 32'h11);
        rd_sel = 4'd1; tick;
        chk("R5 epc1", epc_rd, 32'h2000);
        set_status(8'h20); cur_pc = 32'h2100; tick;
        take_ack = 1'b1; tick; take_ack = 1'b0;
        chk("R5 user vector", redirect_pc, 32'h340);
        chk("R7 user status", status, 32'h31);
        tick;
        chk("R5 epc1 user", epc_rd, 32'h2100);

        // R6 double exception path
        set_status(8'h10); cur_pc = 32'h2200; tick;
        take_ack = 1'b1; tick; take_ack = 1'b0;
        chk("R6 double vector", redirect_pc, 32'h3C0);
        rd_sel = 4'd0; tick;
        chk("R6 depc", epc_rd, 32'h2200);
        rd_sel = 4'd1; tick;
        chk("R6 epc1 kept", epc_rd, 32'h2100);
        rd_sel = 4'd9; tick;
        chk("R12 out of range", epc_rd, 0);

        // R8 ignored returns
        req_lines = '0; set_status(8'h20);
        rfi_go = 1'b1; rfi_lvl = 4'd2; tick; rfi_go = 1'b0;
        chk("R8 user ignored vld", redirect_vld, 0);
        chk("R8 user ignored status", status, 32'h20);
        set_status(8'h00);
        rfi_go = 1'b1; rfi_lvl = 4'd7; tick; rfi_go = 1'b0;
        chk("R8 bad level vld", redirect_vld, 0);
        chk("R8 bad level status", status, 32'h00);

        // R9 wait lowers the level and reopens arbitration
        req_lines = 32'h10; set_status(8'hC5); tick;
        chk("R9 blocked before wait", irq_req, 0);
        wait_go = 1'b1; wait_lvl = 4'd2; tick; wait_go = 1'b0;
        chk("R9 status", status, 32'hC2);
        chk("R9 no redirect", redirect_vld, 0);
        chk("R9 request now", irq_lvl, 3);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule